// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up a bank of 8-bit digital input ports before they reach edge detection or other downstream logic. Every input line first passes through a two-stage synchroniser. A line can be filtered or bypassed, and each port has its own 8-bit mask that selects this bit by bit. A filtered line keeps its previous output level until the synchronised input has held a new level for a programmed number of consecutive 200 ns ticks. Shorter pulses are dropped.

All ports share one 20-bit interval register. A prescaler divides the system clock down to the 200 ns tick, and its division ratio comes from a clock-frequency parameter. Software sets up the block through a byte-wide register port with a one-cycle write strobe and a combinational read path. The interval occupies four byte addresses starting at 0x08, least significant byte first. The mask of port p is at address 0x44 + 0x10*p. After reset the interval and every mask are zero, so all lines pass through with only the synchroniser delay.

Top module: `glitch_filter`

## Requirements
- R1: After reset, the interval bytes (0x08 to 0x0B) and every port mask read zero, and each output equals its input two clock cycles later.
- R2: The interval is 20 bits wide. Address 0x08 holds bits 7:0, 0x09 holds bits 15:8, and bits 3:0 of 0x0A hold bits 19:16. Bits 7:4 of 0x0A and all of 0x0B ignore writes and read zero.
- R3: Port p has a read/write 8-bit mask at address 0x44 + 0x10*p. Mask bit b controls output bit 8*p+b.
- R4: The prescaler produces a one-cycle tick every 200 ns, which is 25 cycles at 125 MHz. Interval N therefore delays a filtered change by at least N-1 and at most N+1 ticks.
- R5: A line whose mask bit is 0 follows its synchronised input with two cycles of latency, and its hold counter stays at zero. Clearing a mask bit during filtering releases the current input at once. Setting it again while the input is steady does not change the output.
- R6: A filtered line ignores any excursion that ends before N consecutive ticks have passed. The output changes only in the cycle after a tick.
- R7: A filtered line takes a new input level only after the level has differed from the output for N consecutive ticks.
- R8: An interval of zero makes every line, masked or not, follow its synchronised input with no added delay.
- R9: Masked and unmasked bits within one port behave independently.
- R10: Writes to addresses outside the interval bytes and the port masks are ignored, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| din_i | input | 8*NPORT | Raw input lines, port p on bits 8p+7:8p |
| dout_o | output | 8*NPORT | Filtered lines |

## Verification
Several properties are checked on every cycle: the prescaler tick period, the two-cycle pass-through of unmasked lines and of all lines when the interval is zero, the rule that a filtered output changes only in the cycle after a tick, and the zero readback of the unused interval bits. Other behaviour appears only over many cycles, so only the bench scenarios can show it. These scenarios are glitch suppression, the acceptance window of a held level measured against the programmed interval, the mixed masks within one port, the release when a mask bit is cleared in mid-count, and the decoding of unmapped addresses.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
  localparam int          IV_W      = 20;
  localparam int          TICK_NS   = 200;
  localparam logic [7:0]  IV_ADDR0  = 8'h08;
  localparam logic [7:0]  IV_ADDR1  = 8'h09;
  localparam logic [7:0]  IV_ADDR2  = 8'h0A;
  localparam logic [7:0]  IV_ADDR3  = 8'h0B;
  localparam int          MASK_BASE = 'h44;
  localparam int          MASK_STEP = 'h10;

  // mask address of port p (NPORT up to 12 fits in 8 bits)
  function automatic logic [7:0] mask_addr(int p);
    return 8'(MASK_BASE + p * MASK_STEP);
  endfunction
endpackage

// File: rtl/gf_prescaler.sv
module gf_prescaler #(
  parameter int TICK_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICK_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gf_regs.sv
module gf_regs
  import glitch_filter_pkg::*;
#(
  parameter int NPORT = 4,
  localparam int W = NPORT * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [7:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic [IV_W-1:0] iv_o,
  output logic [W-1:0]    en_o
);
  logic [IV_W-1:0] iv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q <= '0;
    end else if (we_i) begin
      if (addr_i == IV_ADDR0) iv_q[7:0]   <= wdata_i;
      if (addr_i == IV_ADDR1) iv_q[15:8]  <= wdata_i;
      if (addr_i == IV_ADDR2) iv_q[19:16] <= wdata_i[3:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_mask
    localparam logic [7:0] A = mask_addr(p);
    logic [7:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  mask_q <= '0;
      else if (we_i && addr_i == A) mask_q <= wdata_i;
    end
    assign en_o[p*8 +: 8] = mask_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == IV_ADDR0) rdata_o = iv_q[7:0];
    if (addr_i == IV_ADDR1) rdata_o = iv_q[15:8];
    if (addr_i == IV_ADDR2) rdata_o = {4'b0, iv_q[19:16]};
    for (int p = 0; p < NPORT; p++)
      if (addr_i == mask_addr(p)) rdata_o = en_o[p*8 +: 8];
  end

  assign iv_o = iv_q;
endmodule

// File: rtl/gf_bit_filter.sv
module gf_bit_filter
  import glitch_filter_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [IV_W-1:0] iv_i,
  input  logic            en_i,
  input  logic            sync_i,
  output logic            out_o
);
  logic            filt_q;
  logic [IV_W-1:0] cnt_q;
  logic            active;

  assign active = en_i && (iv_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!active) begin
      // bypassed: track input so re-enable causes no jump
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (sync_i == filt_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q >= iv_i - 1'b1) begin
        filt_q <= sync_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = active ? filt_q : sync_i;
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import glitch_filter_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int CLK_MHZ = 125
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic [NPORT*8-1:0] din_i,
  output logic [NPORT*8-1:0] dout_o
);
  localparam int W        = NPORT * 8;
  localparam int TICK_RAW = CLK_MHZ * TICK_NS / 1000;
  localparam int TICK_CYC = (TICK_RAW < 1) ? 1 : TICK_RAW;

  logic            tick;
  logic [IV_W-1:0] iv;
  logic [W-1:0]    en;
  logic [W-1:0]    sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= din_i;
      sync2_q <= sync1_q;
    end
  end

  gf_prescaler #(.TICK_CYC(TICK_CYC)) i_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  gf_regs #(.NPORT(NPORT)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .iv_o(iv), .en_o(en)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    gf_bit_filter i_flt (
      .clk_i, .rst_ni,
      .tick_i(tick), .iv_i(iv), .en_i(en[b]),
      .sync_i(sync2_q[b]), .out_o(dout_o[b])
    );
  end
endmodule

// File: rtl/glitch_filter_chk.sv
module glitch_filter_chk
  import glitch_filter_pkg::*;
#(
  parameter int W        = 32,
  parameter int TICK_CYC = 25
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [W-1:0]    din_i,
  input logic [W-1:0]    dout_i,
  input logic            tick_i,
  input logic [IV_W-1:0] iv_i,
  input logic [W-1:0]    en_i,
  input logic [7:0]      addr_i,
  input logic [7:0]      rdata_i
);
  int unsigned cyc;
  int unsigned gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc <= 0;
      gap <= 0;
    end else begin
      if (cyc < 3) cyc <= cyc + 1;
      gap <= tick_i ? 0 : gap + 1;
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> gap == TICK_CYC - 1); // R4

  AST_BYPASS_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc >= 2 |-> ((dout_i ^ $past(din_i, 2)) & ~en_i) == '0); // R5

  AST_ZERO_INTERVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2 && iv_i == '0) |-> dout_i == $past(din_i, 2)); // R8

  AST_CHANGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 1 && iv_i != '0 && $past(iv_i) != '0 &&
     ((dout_i ^ $past(dout_i)) & en_i & $past(en_i)) != '0) |-> $past(tick_i)); // R6

  AST_IV_TOP_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == IV_ADDR3 |-> rdata_i == 8'h00); // R2

  AST_IV_HIGH_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == IV_ADDR2 |-> rdata_i[7:4] == 4'h0); // R2
endmodule

bind glitch_filter glitch_filter_chk #(.W(W), .TICK_CYC(TICK_CYC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_i), .dout_i(dout_o),
  .tick_i(tick), .iv_i(iv), .en_i(en),
  .addr_i(reg_addr_i), .rdata_i(reg_rdata_o)
);

// File: tb/test_glitch_filter.sv
module test_glitch_filter;
  localparam int NPORT = 4;
  localparam int W     = NPORT * 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  always #4 clk = ~clk;

  glitch_filter #(.NPORT(NPORT), .CLK_MHZ(125)) i_glitch_filter (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .din_i(din), .dout_o(dout)
  );

  typedef struct {
    string        req;
    bit           is_reg;
    logic [W-1:0] exp;
    logic [W-1:0] mask;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // monitor: compares queued expectations 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = q.pop_front();
        act = it.is_reg ? W'(rdata) : dout;
        n_tests++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (mask %h)",
                   it.req, act & it.mask, it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic exp_reg(string req, logic [7:0] a, logic [7:0] e);
    item_t it;
    addr = a;
    it.req = req; it.is_reg = 1'b1; it.exp = W'(e); it.mask = W'(8'hFF);
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_out(string req, logic [W-1:0] e, logic [W-1:0] m);
    item_t it;
    it.req = req; it.is_reg = 1'b0; it.exp = e; it.mask = m;
    q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    exp_reg("R1 iv byte0", 8'h08, 8'h00);
    exp_reg("R1 iv byte2", 8'h0A, 8'h00);
    exp_reg("R1 mask p0", 8'h44, 8'h00);
    exp_reg("R1 mask p3", 8'h74, 8'h00);
    din = 32'hA5A5_3C3C;
    wait_cyc(3);
    exp_out("R1 pass-through after reset", 32'hA5A5_3C3C, '1);

    // R2 interval fields
    reg_wr(8'h08, 8'h34);
    reg_wr(8'h09, 8'h12);
    reg_wr(8'h0A, 8'hFF);
    reg_wr(8'h0B, 8'hFF);
    exp_reg("R2 iv byte0", 8'h08, 8'h34);
    exp_reg("R2 iv byte1", 8'h09, 8'h12);
    exp_reg("R2 iv byte2 upper nibble", 8'h0A, 8'h0F);
    exp_reg("R2 iv byte3", 8'h0B, 8'h00);

    // R10 unmapped
    reg_wr(8'h20, 8'hFF);
    exp_reg("R10 unmapped 0x20", 8'h20, 8'h00);
    reg_wr(8'h45, 8'hAA);
    exp_reg("R10 unmapped 0x45", 8'h45, 8'h00);

    // R3 masks
    reg_wr(8'h64, 8'h0F);
    exp_reg("R3 mask p2", 8'h64, 8'h0F);
    reg_wr(8'h74, 8'hC3);
    exp_reg("R3 mask p3", 8'h74, 8'hC3);
    reg_wr(8'h64, 8'h00);
    reg_wr(8'h74, 8'h00);
    exp_reg("R3 mask p2 cleared", 8'h64, 8'h00);

    // filtering, interval 3 ticks
    reg_wr(8'h08, 8'h03);
    reg_wr(8'h09, 8'h00);
    reg_wr(8'h0A, 8'h00);
    din = '0;
    wait_cyc(10);
    reg_wr(8'h44, 8'hFF);
    exp_reg("R3 mask p0", 8'h44, 8'hFF);
    exp_out("R7 settled low", '0, 32'h0000_00FF);

    // R6 glitch of 20 cycles
    din[7:0] = 8'hFF;
    wait_cyc(20);
    exp_out("R6 during glitch", '0, 32'h0000_00FF);
    din[7:0] = 8'h00;
    wait_cyc(100);
    exp_out("R6 glitch suppressed", '0, 32'h0000_00FF);

    // R7 held level
    din[7:0] = 8'hFF;
    wait_cyc(45);
    exp_out("R7 not before N-1 ticks", '0, 32'h0000_00FF);
    wait_cyc(60);
    exp_out("R7 accepted after N+1 ticks", 32'h0000_00FF, 32'h0000_00FF);

    // R9 mixed mask in port 1
    reg_wr(8'h54, 8'h0F);
    din[15:8] = 8'hFF;
    wait_cyc(4);
    exp_out("R9 unmasked upper bits pass", 32'h0000_F000, 32'h0000_FF00);
    wait_cyc(105);
    exp_out("R9 masked lower bits follow", 32'h0000_FF00, 32'h0000_FF00);

    // R5 release in mid-count, then re-enable
    din[7:0] = 8'h00;
    wait_cyc(40);
    exp_out("R5 still held", 32'h0000_00FF, 32'h0000_00FF);
    reg_wr(8'h44, 8'h00);
    exp_out("R5 release on mask clear", '0, 32'h0000_00FF);
    reg_wr(8'h44, 8'hFF);
    wait_cyc(5);
    exp_out("R5 no jump on re-enable", '0, 32'h0000_00FF);

    // R4 tick period via interval 8
    reg_wr(8'h08, 8'h08);
    din[7:0] = 8'hFF;
    wait_cyc(170);
    exp_out("R4 held below 7 ticks", '0, 32'h0000_00FF);
    wait_cyc(60);
    exp_out("R4 accepted by 9 ticks", 32'h0000_00FF, 32'h0000_00FF);

    // R8 zero interval
    reg_wr(8'h08, 8'h00);
    din[15:0] = 16'h815A;
    wait_cyc(3);
    exp_out("R8 zero interval pass-through", 32'h0000_815A, 32'h0000_FFFF);

    wait_cyc(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule